// File: doc/BRIEF.md
# EPROM Word Programming Sequencer

This block steps an external UV-erasable PROM through the write of one word at a time. A host hands it an address, a data byte and a verify flag over a valid/ready handshake. The sequencer then drives the address and data pins with output-enable held high, fires one timed active-high program pulse, holds the pins steady, and, when asked, reads the word back with the programming voltage still applied. It returns one response per command that carries a status code and the byte it read.

Every duration is given in nanoseconds and turned into a clock-cycle count from a clock-frequency parameter. The requested pulse width is clamped into a legal minimum/maximum window before it is converted. The block does not make any voltage. It only drives an enable for the external high-voltage switch, and that enable is gated by a logic-supply-ready input. Commands may target any address in any order.

Top module: `eprom_prog_seq`

## Requirements
- R1: `cmd_ready_o` is high only while the sequencer is idle. A command is taken on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both high. Each accepted command produces exactly one `rsp_valid_o` pulse, one cycle wide.
- R2: After acceptance with the supply ready, `addr_o` and `dq_o` carry the command, `dq_oe_o` is high, `oe_n_o` is high and `vpp_en_o` is high for exactly SETUP cycles before `pgm_o` rises.
- R3: `pgm_o` is one unbroken high pulse. Its length in cycles is the requested pulse width, clamped into [min, max] and converted with round-up. It always returns low afterwards.
- R4: After `pgm_o` falls, address, data, `dq_oe_o` high and `oe_n_o` high are held for exactly HOLD cycles.
- R5: With verify set, the sequencer then releases the data bus (`dq_oe_o` low) and drives `oe_n_o` low with `pgm_o` low for exactly SETTLE cycles. It samples `dq_i` on the last of those cycles and returns the sample on `rsp_rdata_o`.
- R6: The verify status is 2'd1 (program fail) when a bit the command wants as 0 reads 1. It is 2'd2 (unerased) when no such bit exists but a bit wanted as 1 reads 0. Otherwise it is 2'd0 (pass). Program fail outranks unerased.
- R7: With verify clear, no read phase occurs: `oe_n_o` stays high, the status is 2'd0 and `rsp_rdata_o` is 8'h00.
- R8: `vpp_en_o` is never high while `vcc_ok_i` is low. A command accepted while `vcc_ok_i` is low returns status 2'd3 with no program pulse and `vpp_en_o` never raised.
- R9: If `vcc_ok_i` drops during setup, pulse, hold or verify, `vpp_en_o` falls in the same cycle. `pgm_o` is low from the next cycle on, and the response carries status 2'd3.
- R10: Under reset, `cmd_ready_o` is high, `oe_n_o` is high, and `pgm_o`, `dq_oe_o`, `vpp_en_o` and `rsp_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vcc_ok_i | input | 1 | Logic supply ready flag |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Sequencer idle, command accepted |
| cmd_addr_i | input | AW | Word address |
| cmd_data_i | input | DW | Byte to program |
| cmd_verify_i | input | 1 | Perform read-back after programming |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_status_o | output | 2 | 0 pass, 1 program fail, 2 unerased, 3 supply fault |
| rsp_rdata_o | output | DW | Byte read in the verify phase |
| addr_o | output | AW | Address pins to the PROM |
| dq_o | output | DW | Data driven to the PROM |
| dq_oe_o | output | 1 | Data bus driver enable |
| dq_i | input | DW | Data read from the PROM |
| pgm_o | output | 1 | Chip-enable/program line, pulsed high to program |
| oe_n_o | output | 1 | Output enable, active low |
| vpp_en_o | output | 1 | Enable for the external programming voltage switch |

## Verification
The bench counts the cycles of each phase at the pins, so a counter loaded one cycle off shows up as a setup, pulse, hold or settle length one cycle wrong. The requested pulse is deliberately set above the maximum, so a design that skips the clamp produces a pulse that is too long. Read-back values are chosen to hit a program failure alone, unerased alone, and both at once. This catches a comparator that tests only one direction or swaps the priority. A supply drop in the middle of a pulse and a command sent with the supply down catch a design that leaves the high-voltage enable up, completes the pulse, or reports a pass.

// File: rtl/eprom_seq_pkg.sv
package eprom_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_PULSE, S_HOLD, S_VERIFY, S_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    RSP_PASS      = 2'd0,
    RSP_PROG_FAIL = 2'd1,
    RSP_UNERASED  = 2'd2,
    RSP_SUPPLY    = 2'd3
  } rsp_code_e;

  // round up, never below one cycle
  function automatic longint ns_to_cyc(longint hz, longint ns);
    longint c;
    c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    return (c < 1) ? 64'd1 : c;
  endfunction

  function automatic longint clamp_ns(longint v, longint lo, longint hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/seq_verify_cmp.sv
module seq_verify_cmp
  import eprom_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] want_i,
  input  logic [DW-1:0] got_i,
  output rsp_code_e     code_o
);
  logic prog_fail, unerased;

  assign prog_fail = |(~want_i & got_i);  // wanted 0, still 1
  assign unerased  = |(want_i & ~got_i);  // wanted 1, already 0

  always_comb begin
    if (prog_fail)     code_o = RSP_PROG_FAIL;
    else if (unerased) code_o = RSP_UNERASED;
    else               code_o = RSP_PASS;
  end
endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eprom_seq_pkg::*;
#(
  parameter int     AW           = 11,
  parameter int     DW           = 8,
  parameter longint CLK_HZ       = 10_000_000,
  parameter longint SETUP_NS     = 2_000,
  parameter longint HOLD_NS      = 2_000,
  parameter longint PULSE_NS     = 50_000_000,
  parameter longint PULSE_MIN_NS = 45_000_000,
  parameter longint PULSE_MAX_NS = 55_000_000,
  parameter int     SETTLE_CYC   = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vcc_ok_i,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [DW-1:0] cmd_data_i,
  input  logic          cmd_verify_i,
  output logic          rsp_valid_o,
  output logic [1:0]    rsp_status_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  input  logic [DW-1:0] dq_i,
  output logic          pgm_o,
  output logic          oe_n_o,
  output logic          vpp_en_o
);
  localparam int SETUP_CYC = int'(ns_to_cyc(CLK_HZ, SETUP_NS));
  localparam int HOLD_CYC  = int'(ns_to_cyc(CLK_HZ, HOLD_NS));
  localparam int PULSE_CYC =
    int'(ns_to_cyc(CLK_HZ, clamp_ns(PULSE_NS, PULSE_MIN_NS, PULSE_MAX_NS)));
  localparam int SET_CYC   = (SETTLE_CYC < 1) ? 1 : SETTLE_CYC;
  localparam int MAX_A     = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int MAX_B     = (PULSE_CYC > SET_CYC) ? PULSE_CYC : SET_CYC;
  localparam int MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW        = $clog2(MAX_CYC + 1);

  seq_state_e    state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, rdata_q;
  logic          verify_q, vpp_q;
  rsp_code_e     status_q, status_d, cmp_code;
  logic          set_status, capture_rd, accept;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;

  seq_timer #(.W(TW)) timer_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  seq_verify_cmp #(.DW(DW)) cmp_i (
    .want_i (data_q),
    .got_i  (dq_i),
    .code_o (cmp_code)
  );

  assign accept = (state_q == S_IDLE) && cmd_valid_i;

  always_comb begin
    state_d    = state_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    set_status = 1'b0;
    status_d   = RSP_PASS;
    capture_rd = 1'b0;
    unique case (state_q)
      S_IDLE: if (cmd_valid_i) begin
        if (!vcc_ok_i) begin
          state_d = S_DONE; set_status = 1'b1; status_d = RSP_SUPPLY;
        end else begin
          state_d = S_SETUP; tmr_load = 1'b1; tmr_val = TW'(SETUP_CYC - 1);
        end
      end
      S_SETUP, S_PULSE, S_HOLD, S_VERIFY: begin
        if (!vcc_ok_i) begin
          state_d = S_DONE; set_status = 1'b1; status_d = RSP_SUPPLY;
        end else if (tmr_zero) begin
          unique case (state_q)
            S_SETUP: begin
              state_d = S_PULSE; tmr_load = 1'b1; tmr_val = TW'(PULSE_CYC - 1);
            end
            S_PULSE: begin
              state_d = S_HOLD; tmr_load = 1'b1; tmr_val = TW'(HOLD_CYC - 1);
            end
            S_HOLD: begin
              if (verify_q) begin
                state_d = S_VERIFY; tmr_load = 1'b1; tmr_val = TW'(SET_CYC - 1);
              end else begin
                state_d = S_DONE; set_status = 1'b1; status_d = RSP_PASS;
              end
            end
            default: begin
              state_d = S_DONE; set_status = 1'b1; status_d = cmp_code;
              capture_rd = 1'b1;
            end
          endcase
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      addr_q   <= '0;
      data_q   <= '0;
      verify_q <= 1'b0;
      rdata_q  <= '0;
      status_q <= RSP_PASS;
      vpp_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      vpp_q   <= (state_d == S_SETUP) || (state_d == S_PULSE) ||
                 (state_d == S_HOLD)  || (state_d == S_VERIFY);
      if (accept) begin
        addr_q   <= cmd_addr_i;
        data_q   <= cmd_data_i;
        verify_q <= cmd_verify_i;
        rdata_q  <= '0;
      end
      if (capture_rd) rdata_q  <= dq_i;
      if (set_status) status_q <= status_d;
    end
  end

  assign cmd_ready_o  = (state_q == S_IDLE);
  assign rsp_valid_o  = (state_q == S_DONE);
  assign rsp_status_o = status_q;
  assign rsp_rdata_o  = rdata_q;
  assign addr_o       = addr_q;
  assign dq_o         = data_q;
  assign dq_oe_o      = (state_q == S_SETUP) || (state_q == S_PULSE) ||
                        (state_q == S_HOLD);
  assign pgm_o        = (state_q == S_PULSE);
  assign oe_n_o       = (state_q != S_VERIFY);
  assign vpp_en_o     = vpp_q & vcc_ok_i;
endmodule

// File: rtl/eprom_prog_seq_chk.sv
module eprom_prog_seq_chk #(
  parameter int AW        = 11,
  parameter int DW        = 8,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          vcc_ok_i,
  input logic          cmd_ready_o,
  input logic          rsp_valid_o,
  input logic [AW-1:0] addr_o,
  input logic [DW-1:0] dq_o,
  input logic          dq_oe_o,
  input logic          pgm_o,
  input logic          oe_n_o,
  input logic          vpp_en_o
);
  int unsigned   hi_cnt, stab_cnt;
  logic [AW-1:0] prev_addr;
  logic [DW-1:0] prev_dq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt    <= 0;
      stab_cnt  <= 0;
      prev_addr <= '0;
      prev_dq   <= '0;
    end else begin
      prev_addr <= addr_o;
      prev_dq   <= dq_o;
      hi_cnt    <= pgm_o ? hi_cnt + 1 : 0;
      if (dq_oe_o && oe_n_o && vpp_en_o && !pgm_o &&
          addr_o == prev_addr && dq_o == prev_dq)
        stab_cnt <= stab_cnt + 1;
      else if (!pgm_o)
        stab_cnt <= 0;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !pgm_o && !dq_oe_o && !vpp_en_o);

  p_rsp_one_cycle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_setup_before_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pgm_o) |-> stab_cnt >= SETUP_CYC - 1);

  p_pulse_context_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_o |-> oe_n_o && dq_oe_o);

  p_pulse_max_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_o |-> hi_cnt < PULSE_CYC);

  p_pulse_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pgm_o) && $past(vcc_ok_i) |-> hi_cnt == PULSE_CYC);

  p_pins_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_o && $past(pgm_o) |-> $stable(addr_o) && $stable(dq_o));

  p_read_bus_free_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_o |-> !dq_oe_o && !pgm_o);

  p_vpp_needs_vcc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vpp_en_o |-> vcc_ok_i);

  p_abort_pgm_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vcc_ok_i |=> !pgm_o);
endmodule

bind eprom_prog_seq eprom_prog_seq_chk #(
  .AW(AW), .DW(DW), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .vcc_ok_i    (vcc_ok_i),
  .cmd_ready_o (cmd_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .addr_o      (addr_o),
  .dq_o        (dq_o),
  .dq_oe_o     (dq_oe_o),
  .pgm_o       (pgm_o),
  .oe_n_o      (oe_n_o),
  .vpp_en_o    (vpp_en_o)
);

// File: tb/eprom_prog_seq_tb_top.sv
module eprom_prog_seq_tb_top;
  localparam int AW = 11;
  localparam int DW = 8;
  // 100 MHz: setup 200 ns = 20, hold 300 ns = 30, pulse 1500 clamped to 1200 ns = 120
  localparam int EXP_SETUP  = 20;
  localparam int EXP_PULSE  = 120;
  localparam int EXP_HOLD   = 30;
  localparam int EXP_SETTLE = 5;

  // {addr[11], data[8], verify, readback[8], status[2]}
  localparam int NV = 6;
  localparam logic [29:0] VEC [NV] = '{
    {11'h000, 8'hA5, 1'b1, 8'hA5, 2'd0},
    {11'h7FF, 8'h00, 1'b1, 8'h00, 2'd0},
    {11'h123, 8'h0F, 1'b1, 8'h1F, 2'd1},
    {11'h456, 8'hFF, 1'b1, 8'hFE, 2'd2},
    {11'h010, 8'hF0, 1'b1, 8'hE1, 2'd1},
    {11'h3C3, 8'h5A, 1'b0, 8'h00, 2'd0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          vcc_ok = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic          cmd_verify = 1'b0;
  logic          rsp_valid;
  logic [1:0]    rsp_status;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_out, dq_in = '0;
  logic          dq_oe, pgm, oe_n, vpp_en;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  eprom_prog_seq #(
    .AW(AW), .DW(DW), .CLK_HZ(100_000_000),
    .SETUP_NS(200), .HOLD_NS(300),
    .PULSE_NS(1500), .PULSE_MIN_NS(800), .PULSE_MAX_NS(1200),
    .SETTLE_CYC(EXP_SETTLE)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .vcc_ok_i(vcc_ok),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .cmd_verify_i(cmd_verify),
    .rsp_valid_o(rsp_valid), .rsp_status_o(rsp_status), .rsp_rdata_o(rsp_rdata),
    .addr_o(addr), .dq_o(dq_out), .dq_oe_o(dq_oe), .dq_i(dq_in),
    .pgm_o(pgm), .oe_n_o(oe_n), .vpp_en_o(vpp_en)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // issue one command and measure every phase at the pins
  task automatic run_cmd(logic [AW-1:0] a, logic [DW-1:0] d, logic v,
                         logic [DW-1:0] rb, logic [1:0] exp_st, logic [DW-1:0] exp_rd);
    int n_setup = 0, n_pulse = 0, n_hold = 0, n_ver = 0, guard = 0;
    bit seen_pulse = 0, pins_ok = 1, vpp_ok = 1;
    dq_in = rb;
    @(negedge clk);
    chk("R1 ready before command", cmd_ready, 1);
    cmd_valid = 1; cmd_addr = a; cmd_data = d; cmd_verify = v;
    @(negedge clk);
    cmd_valid = 0;
    while (!rsp_valid && guard < 5000) begin
      if (pgm) begin
        n_pulse++; seen_pulse = 1;
        if (addr !== a || dq_out !== d || !oe_n) pins_ok = 0;
      end else if (dq_oe && !seen_pulse) begin
        n_setup++;
        if (addr !== a || dq_out !== d || !oe_n || !vpp_en) pins_ok = 0;
      end else if (dq_oe) begin
        n_hold++;
        if (addr !== a || dq_out !== d || !oe_n) pins_ok = 0;
      end else if (!oe_n) begin
        n_ver++;
        if (!vpp_en) vpp_ok = 0;
      end
      if (cmd_ready) pins_ok = 0;
      guard++;
      @(negedge clk);
    end
    chk("R2 setup cycles", n_setup, EXP_SETUP);
    chk("R3 clamped pulse cycles", n_pulse, EXP_PULSE);
    chk("R4 hold cycles", n_hold, EXP_HOLD);
    chk("R2 R4 pins steady, oe_n high", pins_ok, 1);
    if (v) begin
      chk("R5 verify settle cycles", n_ver, EXP_SETTLE);
      chk("R5 vpp on in verify", vpp_ok, 1);
    end else begin
      chk("R7 no read phase", n_ver, 0);
    end
    chk("R1 response seen", rsp_valid, 1);
    chk("R6 status", rsp_status, exp_st);
    chk("R5 readback", rsp_rdata, exp_rd);
    @(negedge clk);
    chk("R1 response one cycle", rsp_valid, 0);
    chk("R3 pgm low after", pgm, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    #3;
    chk("R10 ready in reset", cmd_ready, 1);
    chk("R10 pgm in reset", pgm, 0);
    chk("R10 oe_n in reset", oe_n, 1);
    chk("R10 dq_oe in reset", dq_oe, 0);
    chk("R10 vpp in reset", vpp_en, 0);
    chk("R10 rsp in reset", rsp_valid, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      logic [29:0] e;
      e = VEC[i];
      run_cmd(e[29:19], e[18:11], e[10], e[9:2], e[1:0],
              e[10] ? e[9:2] : 8'h00);
    end

    // R8: command with supply down is rejected without any pulse
    begin
      int guard = 0;
      bit bad = 0;
      @(negedge clk);
      vcc_ok = 0;
      cmd_valid = 1; cmd_addr = 11'h055; cmd_data = 8'h00; cmd_verify = 1;
      @(negedge clk);
      cmd_valid = 0;
      while (!rsp_valid && guard < 50) begin
        if (pgm || vpp_en) bad = 1;
        guard++;
        @(negedge clk);
      end
      if (pgm || vpp_en) bad = 1;
      chk("R8 reject response", rsp_valid, 1);
      chk("R8 reject status", rsp_status, 3);
      chk("R8 no pulse no vpp", bad, 0);
      @(negedge clk);
      vcc_ok = 1;
    end

    // R9: supply drops mid pulse
    begin
      int guard = 0;
      @(negedge clk);
      cmd_valid = 1; cmd_addr = 11'h2AA; cmd_data = 8'h33; cmd_verify = 1;
      @(negedge clk);
      cmd_valid = 0;
      while (!pgm && guard < 200) begin guard++; @(negedge clk); end
      repeat (10) @(negedge clk);
      chk("R9 pulse running", pgm, 1);
      vcc_ok = 0;
      #1;
      chk("R9 vpp off at once", vpp_en, 0);
      @(negedge clk);
      chk("R9 pgm low next cycle", pgm, 0);
      chk("R9 response", rsp_valid, 1);
      chk("R9 abort status", rsp_status, 3);
      @(negedge clk);
      vcc_ok = 1;
      @(negedge clk);
    end

    // recovery after abort
    run_cmd(11'h2AA, 8'h33, 1'b1, 8'h33, 2'd0, 8'h33);

    finished = 1;
    summary();
    $finish;
  end
endmodule